// File: doc/BRIEF.md
# Trap entry controller

This block stands next to the control-register file of a small three-level core (machine, supervisor, user). When the pipeline raises a one-cycle trap request, it takes the cause code, a flag that says whether the event is an interrupt or an exception, the address of the faulting instruction and an extra trap value. It then works out which privilege level handles the trap and commits the whole trap entry on one clock edge. That entry covers the cause, return-address and trap-value registers of the handling level, the interrupt-enable stack in the status word and the current privilege. In the cycle after the request it raises a one-cycle redirect strobe with the handler address.

The handling level is found in two stages. A trap taken below machine level moves down to supervisor when its code bit is set in the machine delegation mask. A trap taken in user mode moves further down to user level when the supervisor delegation mask also has that bit set. Interrupts and exceptions each have their own pair of masks. The handler address comes from the trap vector register of the chosen level. Its two low bits select direct mode or vectored mode, and vectored mode spreads interrupts over a table with one word per cause code. The surrounding logic can load privilege and status through a context port, for example when a trap return restores them. Reset puts the block in machine mode with the program counter at a fixed reset vector.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While reset is held and right after it, priv_o is machine (2'b11), every status_o bit is 0, all nine cause/return-address/trap-value outputs are 0, pc_o equals the RESET_VEC parameter and redirect_o is 0. A trap request that arrives while reset is low has no effect.
- R2: A trap taken in machine mode (priv 2'b11) always goes to machine mode, whatever the delegation masks hold. A trap whose code bit is clear in the machine mask of its kind also goes to machine mode.
- R3: A trap taken in supervisor (2'b01) or user (2'b00) mode whose code bit is set in the machine mask goes to supervisor mode. The exception is a trap taken in user mode whose bit is set in both the machine mask and the supervisor mask, which goes to user mode. A user-mode trap whose bit is set only in the supervisor mask goes to machine mode. A trap never lowers the privilege.
- R4: Interrupts (trap_is_irq=1) read only mideleg_i/sideleg_i. Exceptions read only medeleg_i/sedeleg_i. Bit n of a mask stands for cause code n.
- R5: On entry to machine mode, status_o[8:7] (previous privilege) takes the old privilege and status_o[5] takes the old status_o[2]. status_o[2] (machine enable) is then cleared. No other status bit changes.
- R6: On entry to supervisor mode, status_o[6] takes bit 0 of the old privilege (1 for supervisor, 0 for user). status_o[4] takes the old status_o[1]. status_o[1] is cleared. No other status bit changes.
- R7: On entry to user mode, status_o[3] takes the old status_o[0] and status_o[0] is cleared. No other status bit changes.
- R8: The cause output of the handling level becomes {trap_is_irq, zeros, trap_code}, with the flag in bit XLEN-1. Its return-address output becomes trap_pc and its trap-value output becomes trap_val. The registers of the other two levels keep their values.
- R9: The handler base is the handling level's vector register with bits [1:0] forced to 0. When bits [1:0] equal 1 and the trap is an interrupt, pc_o becomes base + 4*code. In every other case pc_o becomes the base.
- R10: A trap request in cycle k makes redirect_o high in cycle k+1 only. The privilege, status, registers and pc_o change on that same edge. Without a request redirect_o stays low and pc_o holds its value.
- R11: With ctx_we high and no trap request, priv_o and status_o take ctx_priv and ctx_status on the next edge. When a trap request and ctx_we arrive in the same cycle, the trap wins and the context write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_req | input | 1 | One-cycle trap request |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | CODE_W | Cause code |
| trap_pc | input | XLEN | Address of the trapping instruction |
| trap_val | input | XLEN | Trap value |
| mideleg_i | input | XLEN | Machine interrupt delegation mask |
| medeleg_i | input | XLEN | Machine exception delegation mask |
| sideleg_i | input | XLEN | Supervisor interrupt delegation mask |
| sedeleg_i | input | XLEN | Supervisor exception delegation mask |
| mtvec_i | input | XLEN | Machine trap vector |
| stvec_i | input | XLEN | Supervisor trap vector |
| utvec_i | input | XLEN | User trap vector |
| ctx_we | input | 1 | Context load enable |
| ctx_priv | input | 2 | Privilege to load |
| ctx_status | input | 10 | Status word to load |
| priv_o | output | 2 | Current privilege |
| status_o | output | 10 | Status word: [0] uie, [1] sie, [2] mie, [3] upie, [4] spie, [5] mpie, [6] spp, [8:7] mpp, [9] mprv |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine return address |
| mtval_o | output | XLEN | Machine trap value |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor return address |
| stval_o | output | XLEN | Supervisor trap value |
| ucause_o | output | XLEN | User cause |
| uepc_o | output | XLEN | User return address |
| utval_o | output | XLEN | User trap value |
| redirect_o | output | 1 | One-cycle redirect strobe |
| pc_o | output | XLEN | Redirect target / reset vector |

## Verification
Every trap commits in one registered step, so a wrong target choice or a wrong stacked bit shows at the ports in the cycle after the request. It appears there as the wrong privilege, a write to the wrong level's registers, or a status word off by one field. A corrupted privilege that a context load left behind shows up at the next trap, because that trap's target choice and the stacked previous-privilege field both depend on it. The sweep covers every source level, kind, code and delegation-bit pair. Each trap is checked on all outputs, including the registers of the levels that must stay unchanged.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_R = 2'b10,
        PRIV_M = 2'b11
    } priv_e;

    // Status word, MSB first: [9] mprv, [8:7] mpp, [6] spp, [5] mpie,
    // [4] spie, [3] upie, [2] mie, [1] sie, [0] uie
    typedef struct packed {
        logic       mprv;
        logic [1:0] mpp;
        logic       spp;
        logic       mpie;
        logic       spie;
        logic       upie;
        logic       mie;
        logic       sie;
        logic       uie;
    } status_t;

    localparam int STATUS_W = $bits(status_t);
    localparam int NUM_LVL  = 3;
    localparam int LVL_U    = 0;
    localparam int LVL_S    = 1;
    localparam int LVL_M    = 2;

    function automatic priv_e lvl_to_priv(input int lvl);
        case (lvl)
            LVL_U:   return PRIV_U;
            LVL_S:   return PRIV_S;
            default: return PRIV_M;
        endcase
    endfunction

endpackage

// File: rtl/trap_target_sel.sv
module trap_target_sel
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  priv_e             cur_priv,
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   m_irq_mask,
    input  logic [XLEN-1:0]   m_exc_mask,
    input  logic [XLEN-1:0]   s_irq_mask,
    input  logic [XLEN-1:0]   s_exc_mask,
    output priv_e             target
);

    logic [XLEN-1:0] m_mask;
    logic [XLEN-1:0] s_mask;
    logic            m_hit;
    logic            s_hit;

    always_comb begin
        m_mask = is_irq ? m_irq_mask : m_exc_mask;
        s_mask = is_irq ? s_irq_mask : s_exc_mask;
        m_hit  = m_mask[code];
        s_hit  = s_mask[code];
    end

    // Stage one: leave machine level; stage two: leave supervisor level.
    always_comb begin
        target = PRIV_M;
        if (cur_priv != PRIV_M && m_hit) begin
            target = PRIV_S;
            if (cur_priv == PRIV_U && s_hit) begin
                target = PRIV_U;
            end
        end
    end

endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic [XLEN-1:0]   tvec,
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   handler
);

    localparam logic [1:0] MODE_VECTORED = 2'd1;

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    always_comb begin
        base   = {tvec[XLEN-1:2], 2'b00};
        offset = '0;
        offset[CODE_W+1:0] = {code, 2'b00};
        if (is_irq && tvec[1:0] == MODE_VECTORED) begin
            handler = base + offset;
        end else begin
            handler = base;
        end
    end

endmodule

// File: rtl/trap_level_bank.sv
module trap_level_bank #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              wr_en,
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   epc_in,
    input  logic [XLEN-1:0]   tval_in,
    output logic [XLEN-1:0]   cause_o,
    output logic [XLEN-1:0]   epc_o,
    output logic [XLEN-1:0]   tval_o
);

    typedef struct packed {
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] tval;
    } bank_t;

    bank_t bank_d;
    bank_t bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            bank_d.cause               = '0;
            bank_d.cause[XLEN-1]       = is_irq;
            bank_d.cause[CODE_W-1:0]   = code;
            bank_d.epc                 = epc_in;
            bank_d.tval                = tval_in;
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign cause_o = bank_q.cause;
    assign epc_o   = bank_q.epc;
    assign tval_o  = bank_q.tval;

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              CODE_W    = 5,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic              trap_req,
    input  logic              trap_is_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_val,
    input  logic [XLEN-1:0]   mideleg_i,
    input  logic [XLEN-1:0]   medeleg_i,
    input  logic [XLEN-1:0]   sideleg_i,
    input  logic [XLEN-1:0]   sedeleg_i,
    input  logic [XLEN-1:0]   mtvec_i,
    input  logic [XLEN-1:0]   stvec_i,
    input  logic [XLEN-1:0]   utvec_i,
    input  logic              ctx_we,
    input  logic [1:0]        ctx_priv,
    input  logic [9:0]        ctx_status,
    output logic [1:0]        priv_o,
    output logic [9:0]        status_o,
    output logic [XLEN-1:0]   mcause_o,
    output logic [XLEN-1:0]   mepc_o,
    output logic [XLEN-1:0]   mtval_o,
    output logic [XLEN-1:0]   scause_o,
    output logic [XLEN-1:0]   sepc_o,
    output logic [XLEN-1:0]   stval_o,
    output logic [XLEN-1:0]   ucause_o,
    output logic [XLEN-1:0]   uepc_o,
    output logic [XLEN-1:0]   utval_o,
    output logic              redirect_o,
    output logic [XLEN-1:0]   pc_o
);

    typedef struct packed {
        priv_e           priv;
        status_t         status;
        logic [XLEN-1:0] pc;
        logic            redirect;
    } ctrl_t;

    ctrl_t           ctrl_d;
    ctrl_t           ctrl_q;
    priv_e           target;
    logic [XLEN-1:0] sel_tvec;
    logic [XLEN-1:0] handler;

    logic [XLEN-1:0] cause_arr [NUM_LVL];
    logic [XLEN-1:0] epc_arr   [NUM_LVL];
    logic [XLEN-1:0] tval_arr  [NUM_LVL];

    trap_target_sel #(
        .XLEN   (XLEN),
        .CODE_W (CODE_W)
    ) u_sel (
        .cur_priv   (ctrl_q.priv),
        .is_irq     (trap_is_irq),
        .code       (trap_code),
        .m_irq_mask (mideleg_i),
        .m_exc_mask (medeleg_i),
        .s_irq_mask (sideleg_i),
        .s_exc_mask (sedeleg_i),
        .target     (target)
    );

    always_comb begin
        case (target)
            PRIV_U:  sel_tvec = utvec_i;
            PRIV_S:  sel_tvec = stvec_i;
            default: sel_tvec = mtvec_i;
        endcase
    end

    trap_vector_calc #(
        .XLEN   (XLEN),
        .CODE_W (CODE_W)
    ) u_vec (
        .tvec    (sel_tvec),
        .is_irq  (trap_is_irq),
        .code    (trap_code),
        .handler (handler)
    );

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_bank
        logic wr_sel;
        assign wr_sel = trap_req && (target == lvl_to_priv(g));
        trap_level_bank #(
            .XLEN   (XLEN),
            .CODE_W (CODE_W)
        ) u_bank (
            .clk     (clk),
            .rst_ni  (rst_ni),
            .wr_en   (wr_sel),
            .is_irq  (trap_is_irq),
            .code    (trap_code),
            .epc_in  (trap_pc),
            .tval_in (trap_val),
            .cause_o (cause_arr[g]),
            .epc_o   (epc_arr[g]),
            .tval_o  (tval_arr[g])
        );
    end

    always_comb begin
        ctrl_d          = ctrl_q;
        ctrl_d.redirect = 1'b0;
        if (trap_req) begin
            ctrl_d.priv     = target;
            ctrl_d.pc       = handler;
            ctrl_d.redirect = 1'b1;
            case (target)
                PRIV_U: begin
                    ctrl_d.status.upie = ctrl_q.status.uie;
                    ctrl_d.status.uie  = 1'b0;
                end
                PRIV_S: begin
                    ctrl_d.status.spp  = ctrl_q.priv[0];
                    ctrl_d.status.spie = ctrl_q.status.sie;
                    ctrl_d.status.sie  = 1'b0;
                end
                default: begin
                    ctrl_d.status.mpp  = ctrl_q.priv;
                    ctrl_d.status.mpie = ctrl_q.status.mie;
                    ctrl_d.status.mie  = 1'b0;
                end
            endcase
        end else if (ctx_we) begin
            ctrl_d.priv   = priv_e'(ctx_priv);
            ctrl_d.status = status_t'(ctx_status);
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q.priv     <= PRIV_M;
            ctrl_q.status   <= '0;
            ctrl_q.pc       <= RESET_VEC;
            ctrl_q.redirect <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign priv_o     = ctrl_q.priv;
    assign status_o   = ctrl_q.status;
    assign pc_o       = ctrl_q.pc;
    assign redirect_o = ctrl_q.redirect;
    assign mcause_o   = cause_arr[LVL_M];
    assign mepc_o     = epc_arr[LVL_M];
    assign mtval_o    = tval_arr[LVL_M];
    assign scause_o   = cause_arr[LVL_S];
    assign sepc_o     = epc_arr[LVL_S];
    assign stval_o    = tval_arr[LVL_S];
    assign ucause_o   = cause_arr[LVL_U];
    assign uepc_o     = epc_arr[LVL_U];
    assign utval_o    = tval_arr[LVL_U];

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_ni,
    input logic            trap_req,
    input logic            ctx_we,
    input logic [1:0]      ctx_priv,
    input logic [1:0]      priv_o,
    input logic [9:0]      status_o,
    input logic            redirect_o,
    input logic [XLEN-1:0] pc_o
);

    // R10: a request produces the strobe on the next cycle
    a_r10_strobe_follows: assert property (@(posedge clk) disable iff (!rst_ni)
        trap_req |=> redirect_o);

    // R10: no request, no strobe and a steady target
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
        !trap_req |=> (!redirect_o && $stable(pc_o)));

    // R2: machine-mode traps stay in machine mode
    a_r2_m_stays_m: assert property (@(posedge clk) disable iff (!rst_ni)
        (trap_req && priv_o == 2'b11) |=> priv_o == 2'b11);

    // R3: a trap never lowers the privilege
    a_r3_no_demote: assert property (@(posedge clk) disable iff (!rst_ni)
        trap_req |=> priv_o >= $past(priv_o));

    // R5: machine enable is off after entering machine mode
    a_r5_mie_off: assert property (@(posedge clk) disable iff (!rst_ni)
        trap_req |=> (priv_o != 2'b11 || !status_o[2]));

    // R6: supervisor enable is off after entering supervisor mode
    a_r6_sie_off: assert property (@(posedge clk) disable iff (!rst_ni)
        trap_req |=> (priv_o != 2'b01 || !status_o[1]));

    // R7: user enable is off after entering user mode
    a_r7_uie_off: assert property (@(posedge clk) disable iff (!rst_ni)
        trap_req |=> (priv_o != 2'b00 || !status_o[0]));

    // R9: a handler address is always word aligned
    a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_ni)
        redirect_o |-> pc_o[1:0] == 2'b00);

    // R11: a context load without a trap lands on the next edge
    a_r11_ctx_load: assert property (@(posedge clk) disable iff (!rst_ni)
        (ctx_we && !trap_req) |=> priv_o == $past(ctx_priv));

endmodule

bind trap_entry_ctrl trap_entry_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .trap_req   (trap_req),
    .ctx_we     (ctx_we),
    .ctx_priv   (ctx_priv),
    .priv_o     (priv_o),
    .status_o   (status_o),
    .redirect_o (redirect_o),
    .pc_o       (pc_o)
);

// File: tb/sim_trap_entry_ctrl.sv
`timescale 1ns/1ps
module sim_trap_entry_ctrl;

    localparam int          XLEN   = 32;
    localparam int          CODE_W = 4;
    localparam logic [31:0] RVEC   = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        trap_req = 1'b0;
    logic        trap_is_irq = 1'b0;
    logic [3:0]  trap_code = '0;
    logic [31:0] trap_pc = '0, trap_val = '0;
    logic [31:0] mideleg_i = '0, medeleg_i = '0, sideleg_i = '0, sedeleg_i = '0;
    logic [31:0] mtvec_i = '0, stvec_i = '0, utvec_i = '0;
    logic        ctx_we = 1'b0;
    logic [1:0]  ctx_priv = '0;
    logic [9:0]  ctx_status = '0;
    logic [1:0]  priv_o;
    logic [9:0]  status_o;
    logic [31:0] mcause_o, mepc_o, mtval_o, scause_o, sepc_o, stval_o;
    logic [31:0] ucause_o, uepc_o, utval_o, pc_o;
    logic        redirect_o;

    trap_entry_ctrl #(.XLEN(XLEN), .CODE_W(CODE_W), .RESET_VEC(RVEC)) u0 (
        .clk(clk), .rst_ni(rst_ni), .trap_req(trap_req), .trap_is_irq(trap_is_irq),
        .trap_code(trap_code), .trap_pc(trap_pc), .trap_val(trap_val),
        .mideleg_i(mideleg_i), .medeleg_i(medeleg_i), .sideleg_i(sideleg_i),
        .sedeleg_i(sedeleg_i), .mtvec_i(mtvec_i), .stvec_i(stvec_i), .utvec_i(utvec_i),
        .ctx_we(ctx_we), .ctx_priv(ctx_priv), .ctx_status(ctx_status),
        .priv_o(priv_o), .status_o(status_o),
        .mcause_o(mcause_o), .mepc_o(mepc_o), .mtval_o(mtval_o),
        .scause_o(scause_o), .sepc_o(sepc_o), .stval_o(stval_o),
        .ucause_o(ucause_o), .uepc_o(uepc_o), .utval_o(utval_o),
        .redirect_o(redirect_o), .pc_o(pc_o)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    logic [31:0] e_cause [3];
    logic [31:0] e_epc   [3];
    logic [31:0] e_tval  [3];
    logic [1:0]  e_priv;
    logic [9:0]  e_stat;
    logic [31:0] e_pc;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_regs(input string req);
        chk(req, "priv", {30'd0, priv_o}, {30'd0, e_priv});
        chk(req, "status", {22'd0, status_o}, {22'd0, e_stat});
        chk(req, "pc", pc_o, e_pc);
        chk(req, "mcause", mcause_o, e_cause[2]);
        chk(req, "mepc", mepc_o, e_epc[2]);
        chk(req, "mtval", mtval_o, e_tval[2]);
        chk(req, "scause", scause_o, e_cause[1]);
        chk(req, "sepc", sepc_o, e_epc[1]);
        chk(req, "stval", stval_o, e_tval[1]);
        chk(req, "ucause", ucause_o, e_cause[0]);
        chk(req, "uepc", uepc_o, e_epc[0]);
        chk(req, "utval", utval_o, e_tval[0]);
    endtask

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin
            e_cause[i] = '0; e_epc[i] = '0; e_tval[i] = '0;
        end
        e_priv = 2'b11; e_stat = '0; e_pc = RVEC;
    endtask

    // Expected trap entry from the requirement text
    task automatic model_trap(input logic irq, input logic [3:0] code,
                              input logic [31:0] pc, input logic [31:0] val);
        logic [31:0] mm, sm, tv;
        logic [1:0]  tgt;
        int          lvl;
        mm = irq ? mideleg_i : medeleg_i;
        sm = irq ? sideleg_i : sedeleg_i;
        tgt = 2'b11;
        if (e_priv != 2'b11 && mm[code]) tgt = 2'b01;
        if (e_priv == 2'b00 && mm[code] && sm[code]) tgt = 2'b00;
        lvl = (tgt == 2'b11) ? 2 : (tgt == 2'b01) ? 1 : 0;
        tv = (lvl == 2) ? mtvec_i : (lvl == 1) ? stvec_i : utvec_i;
        e_cause[lvl] = {irq, 27'd0, code};
        e_epc[lvl] = pc;
        e_tval[lvl] = val;
        if (lvl == 2) begin
            e_stat[8:7] = e_priv; e_stat[5] = e_stat[2]; e_stat[2] = 1'b0;
        end else if (lvl == 1) begin
            e_stat[6] = e_priv[0]; e_stat[4] = e_stat[1]; e_stat[1] = 1'b0;
        end else begin
            e_stat[3] = e_stat[0]; e_stat[0] = 1'b0;
        end
        e_pc = (tv & ~32'd3) + ((irq && tv[1:0] == 2'd1) ? {26'd0, code, 2'b00} : 32'd0);
        e_priv = tgt;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int trial = 0;
        model_reset();
        repeat (3) @(negedge clk);
        chk_regs("R1");
        chk("R1", "redirect in reset", {31'd0, redirect_o}, 32'd0);
        rst_ni = 1'b1;
        @(negedge clk);
        chk_regs("R1");

        // Sweep: source level, kind, code, machine/supervisor bit
        for (int pi = 0; pi < 3; pi++) begin
            for (int irq = 0; irq < 2; irq++) begin
                for (int code = 0; code < 16; code++) begin
                    for (int dm = 0; dm < 2; dm++) begin
                        for (int ds = 0; ds < 2; ds++) begin
                            logic [1:0]  p;
                            logic [31:0] bit1, noise, mpat, spat;
                            p = (pi == 0) ? 2'b00 : (pi == 1) ? 2'b01 : 2'b11;
                            bit1 = 32'd1 << code;
                            noise = 32'h5A5A_5A5A ^ (trial * 32'h0000_9E37);
                            mpat = (noise & ~bit1) | (dm[0] ? bit1 : 32'd0);
                            spat = (~noise & ~bit1) | (ds[0] ? bit1 : 32'd0);
                            @(negedge clk);
                            ctx_we = 1'b1; ctx_priv = p;
                            ctx_status = 10'((trial * 37) ^ 10'h2A5);
                            // R4: the opposite-kind masks hold the inverse bit
                            if (irq != 0) begin
                                mideleg_i = mpat; medeleg_i = ~mpat;
                                sideleg_i = spat; sedeleg_i = ~spat;
                            end else begin
                                medeleg_i = mpat; mideleg_i = ~mpat;
                                sedeleg_i = spat; sideleg_i = ~spat;
                            end
                            mtvec_i = 32'h8000_0100 | 32'((code + pi) % 4);
                            stvec_i = 32'h4000_0200 | 32'((code + pi + 1) % 4);
                            utvec_i = 32'h2000_0300 | 32'((code + pi + 2) % 4);
                            @(negedge clk);
                            ctx_we = 1'b0;
                            e_priv = p; e_stat = ctx_status;
                            chk("R11", "ctx priv", {30'd0, priv_o}, {30'd0, e_priv});
                            chk("R11", "ctx status", {22'd0, status_o}, {22'd0, e_stat});
                            trap_req = 1'b1; trap_is_irq = irq[0]; trap_code = code[3:0];
                            trap_pc = (trial << 2) ^ 32'hA500_0000;
                            trap_val = trial * 32'h0101_0101;
                            @(negedge clk);
                            trap_req = 1'b0;
                            model_trap(irq[0], code[3:0], trap_pc, trap_val);
                            // R2 R3 R4 R5 R6 R7 R8 R9 checked through the model
                            chk_regs((pi == 2 || dm == 0) ? "R2" : "R3");
                            chk("R10", "strobe", {31'd0, redirect_o}, 32'd1);
                            @(negedge clk);
                            chk("R10", "strobe drop", {31'd0, redirect_o}, 32'd0);
                            chk("R10", "pc hold", pc_o, e_pc);
                            trial++;
                        end
                    end
                end
            end
        end

        // R11: trap and context load together, trap wins
        @(negedge clk);
        ctx_we = 1'b1; ctx_priv = 2'b01; ctx_status = 10'h3FF;
        @(negedge clk);
        ctx_we = 1'b0; e_priv = 2'b01; e_stat = 10'h3FF;
        medeleg_i = 32'h0; trap_is_irq = 1'b0; trap_code = 4'd3;
        trap_pc = 32'h1234_5678; trap_val = 32'hCAFE_0001; mtvec_i = 32'h9000_0001;
        trap_req = 1'b1; ctx_we = 1'b1; ctx_priv = 2'b00; ctx_status = 10'h000;
        @(negedge clk);
        trap_req = 1'b0; ctx_we = 1'b0;
        model_trap(1'b0, 4'd3, 32'h1234_5678, 32'hCAFE_0001);
        chk_regs("R11");

        // R1: trap raised during a reset pulse is dropped
        @(negedge clk);
        rst_ni = 1'b0; trap_req = 1'b1; trap_is_irq = 1'b1;
        @(negedge clk);
        rst_ni = 1'b1; trap_req = 1'b0;
        model_reset();
        chk_regs("R1");
        chk("R1", "redirect after reset", {31'd0, redirect_o}, 32'd0);
        @(negedge clk);
        chk("R1", "still idle", {31'd0, redirect_o}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule